// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This unit carries out the eight standard 32-bit integer multiply, divide and remainder operations for a processor pipeline. A 3-bit function code chooses the operation, and two 32-bit operands supply the inputs. The caller raises `start_i` for one cycle while the unit is idle. The unit then reports `busy_o` until it pulses `done_o` together with the 32-bit result. That result stays on `result_o` until the next completion.

Products come from one registered multiplier stage, so they finish one cycle after acceptance. Quotients and remainders come from a restoring shift-subtract divider. The divider works on operand magnitudes over 32 iterations, then applies a sign fix-up. A zero divisor does not trap: it yields a fixed result. The overflow case of the most negative value divided by minus one wraps as the integer rules require. Instruction decode, register access and writeback are handled outside this block.

Top module: `muldiv_unit`

## Requirements
- R1: Function code 3'b000 returns bits [31:0] of the product of the two operands.
- R2: Function code 3'b001 returns bits [63:32] of the 64-bit product with both operands taken as two's-complement signed.
- R3: Function code 3'b010 returns bits [63:32] of the 64-bit product with operand A signed and operand B unsigned.
- R4: Function code 3'b011 returns bits [63:32] of the 64-bit product with both operands unsigned.
- R5: Function code 3'b100 is a signed quotient truncated toward zero, and 3'b101 is an unsigned quotient.
- R6: Function code 3'b110 is a signed remainder whose sign follows the dividend, and 3'b111 is an unsigned remainder.
- R7: A quotient (3'b100 or 3'b101) with a zero divisor returns 32'hFFFFFFFF.
- R8: A remainder (3'b110 or 3'b111) with a zero divisor returns operand A unchanged.
- R9: A signed quotient of 32'h80000000 by 32'hFFFFFFFF returns 32'h80000000, and the matching signed remainder returns 0.
- R10: A multiply accepted at clock edge N pulses `done_o` after edge N+1. A divide or remainder accepted at edge N runs its 32 iterations on edges N+1 to N+32 and pulses `done_o` after edge N+33.
- R11: After reset `busy_o`, `done_o` and `result_o` are 0. `start_i` is accepted only while `busy_o` is low, and a start while busy has no effect on any result. `busy_o` is high from the edge that accepts an operation until the edge that raises `done_o`. `done_o` lasts exactly one cycle, and `result_o` changes only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin an operation, taken only when idle |
| func_i | input | 3 | Operation select |
| op_a_i | input | 32 | Operand A (multiplicand or dividend) |
| op_b_i | input | 32 | Operand B (multiplier or divisor) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Result, held until the next completion |

## Verification
A wrong iteration count or a stuck divider sequencer shows up at the ports as `done_o` arriving on the wrong edge. The reference model catches this in the very cycle the pulse should have appeared or vanished. A corrupted remainder register, or a sign flag latched at the wrong moment, is visible only when that operation completes, as a wrong `result_o` in the `done_o` cycle. For this reason the stimulus mixes negative operands, zero divisors and the overflow pair. Operand latches that wrongly follow a start raised while busy show up as a result matching the later operands instead of the accepted ones.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  typedef enum logic [2:0] {
    FN_MUL    = 3'b000,
    FN_MULH   = 3'b001,
    FN_MULHSU = 3'b010,
    FN_MULHU  = 3'b011,
    FN_DIV    = 3'b100,
    FN_DIVU   = 3'b101,
    FN_REM    = 3'b110,
    FN_REMU   = 3'b111
  } mdu_fn_e;

  // signed divide/remainder: bit2 set, bit0 clear
  function automatic logic fn_div_signed(logic [2:0] fn);
    return fn[2] & ~fn[0];
  endfunction
endpackage

// File: rtl/mdu_sign_prep.sv
module mdu_sign_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] val_i,
  input  logic         signed_i,
  output logic         neg_o,
  output logic [W-1:0] mag_o
);
  assign neg_o = signed_i & val_i[W-1];
  assign mag_o = neg_o ? (~val_i + W'(1)) : val_i;
endmodule

// File: rtl/mdu_multiplier.sv
module mdu_multiplier #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         a_signed_i,
  input  logic         b_signed_i,
  input  logic         high_i,
  output logic [W-1:0] prod_o
);
  localparam int PW = 2 * W;

  logic [PW-1:0] a_ext, b_ext, prod;

  // sign extension to 2W; product modulo 2^(2W) is exact for all three signedness mixes
  assign a_ext  = {{W{a_signed_i & a_i[W-1]}}, a_i};
  assign b_ext  = {{W{b_signed_i & b_i[W-1]}}, b_i};
  assign prod   = a_ext * b_ext;
  assign prod_o = high_i ? prod[PW-1:W] : prod[W-1:0];
endmodule

// File: rtl/mdu_divider.sv
module mdu_divider #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         fin_o
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          act_q, fin_q;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= '0;
        act_q <= 1'b1;
      end else if (act_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(W - 1)) begin
          act_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;
  assign fin_o = fin_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       func_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  import mdu_pkg::*;

  logic             accept;
  logic             busy_q, done_q;
  logic [WIDTH-1:0] result_q;
  logic [2:0]       func_q;
  logic [WIDTH-1:0] a_q, b_q;
  logic             q_neg_q, r_neg_q;

  logic [WIDTH-1:0] op_val [2];
  logic [WIDTH-1:0] op_mag [2];
  logic             op_neg [2];
  logic             div_signed;

  assign accept     = start_i & ~busy_q;
  assign div_signed = fn_div_signed(func_i);
  assign op_val[0]  = op_a_i;
  assign op_val[1]  = op_b_i;

  for (genvar i = 0; i < 2; i++) begin : g_prep
    mdu_sign_prep #(.W(WIDTH)) u_prep (
      .val_i   (op_val[i]),
      .signed_i(div_signed),
      .neg_o   (op_neg[i]),
      .mag_o   (op_mag[i])
    );
  end

  logic [WIDTH-1:0] mul_res;
  mdu_multiplier #(.W(WIDTH)) u_mul (
    .a_i       (a_q),
    .b_i       (b_q),
    .a_signed_i(func_q[1:0] == 2'b01 || func_q[1:0] == 2'b10),
    .b_signed_i(func_q[1:0] == 2'b01),
    .high_i    (func_q[1:0] != 2'b00),
    .prod_o    (mul_res)
  );

  logic [WIDTH-1:0] quo_mag, rem_mag;
  logic             div_fin;
  mdu_divider #(.W(WIDTH)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept & func_i[2]),
    .dividend_i(op_mag[0]),
    .divisor_i (op_mag[1]),
    .quo_o     (quo_mag),
    .rem_o     (rem_mag),
    .fin_o     (div_fin)
  );

  // sign fix-up and zero-divisor override
  logic [WIDTH-1:0] div_res;
  always_comb begin
    if (b_q == '0) begin
      div_res = func_q[1] ? a_q : '1;
    end else if (func_q[1]) begin
      div_res = r_neg_q ? (~rem_mag + WIDTH'(1)) : rem_mag;
    end else begin
      div_res = q_neg_q ? (~quo_mag + WIDTH'(1)) : quo_mag;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
      func_q   <= FN_MUL;
      a_q      <= '0;
      b_q      <= '0;
      q_neg_q  <= 1'b0;
      r_neg_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        func_q  <= func_i;
        a_q     <= op_a_i;
        b_q     <= op_b_i;
        q_neg_q <= op_neg[0] ^ op_neg[1];
        r_neg_q <= op_neg[0];
      end else if (busy_q && !func_q[2]) begin
        result_q <= mul_res;
        done_q   <= 1'b1;
        busy_q   <= 1'b0;
      end else if (div_fin) begin
        result_q <= div_res;
        done_q   <= 1'b1;
        busy_q   <= 1'b0;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/mdu_checker.sv
module mdu_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [2:0]   func_i,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] result_o
);
  localparam int CCW = $clog2(W + 2) + 1;
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  logic [2:0]     lf;
  logic [W-1:0]   la, lb;
  logic [CCW-1:0] cyc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lf  <= '0;
      la  <= '0;
      lb  <= '0;
      cyc <= '0;
    end else if (start_i && !busy_o) begin
      lf  <= func_i;
      la  <= op_a_i;
      lb  <= op_b_i;
      cyc <= '0;
    end else if (busy_o) begin
      cyc <= cyc + CCW'(1);
    end
  end

  a_r10_mul_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !lf[2] |-> cyc == CCW'(1));
  a_r10_div_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && lf[2] |-> cyc == CCW'(W + 1));
  a_r11_busy_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r11_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r11_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
  a_r7_div_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && lf[2] && !lf[1] && lb == '0 |-> result_o == '1);
  a_r8_rem_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && lf[2] && lf[1] && lb == '0 |-> result_o == la);
  a_r9_ovf_quo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && lf == 3'b100 && la == MIN_NEG && lb == '1 |-> result_o == MIN_NEG);
  a_r9_ovf_rem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && lf == 3'b110 && la == MIN_NEG && lb == '1 |-> result_o == '0);
endmodule

bind muldiv_unit mdu_checker #(.W(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .func_i  (func_i),
  .op_a_i  (op_a_i),
  .op_b_i  (op_b_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .result_o(result_o)
);

// File: tb/muldiv_unit_bench.sv
`timescale 1ns/1ps
module muldiv_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  func = 3'b000;
  logic [31:0] a = '0, b = '0;
  logic        busy, done;
  logic [31:0] result;

  muldiv_unit #(.WIDTH(32)) u_muldiv_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .func_i(func),
    .op_a_i(a), .op_b_i(b), .busy_o(busy), .done_o(done), .result_o(result)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_calc(logic [2:0] f, logic [31:0] x, logic [31:0] y);
    longint sx, sy, ux, uy, q;
    logic [63:0] p;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    ux = longint'(x);
    uy = longint'(y);
    case (f)
      3'b000: begin p = 64'(sx * sy); return p[31:0]; end
      3'b001: begin p = 64'(sx * sy); return p[63:32]; end
      3'b010: begin p = 64'(sx * uy); return p[63:32]; end
      3'b011: begin p = {32'b0, x} * {32'b0, y}; return p[63:32]; end
      3'b100: begin if (y == 0) return '1; q = sx / sy; return q[31:0]; end
      3'b101: begin if (y == 0) return '1; q = ux / uy; return q[31:0]; end
      3'b110: begin if (y == 0) return x; q = sx % sy; return q[31:0]; end
      default: begin if (y == 0) return x; q = ux % uy; return q[31:0]; end
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] f, logic [31:0] x, logic [31:0] y);
    if (f[2] && y == 0) return f[1] ? "R8" : "R7";
    if ((f == 3'b100 || f == 3'b110) && x == 32'h80000000 && y == '1) return "R9";
    case (f)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100, 3'b101: return "R5";
      default: return "R6";
    endcase
  endfunction

  // behavioural reference: operation queue of depth one with a cycle countdown
  bit          m_busy = 1'b0;
  int          m_left = 0;
  logic [31:0] m_res = '0;
  string       m_tag = "R11";
  bit          exp_done = 1'b0;
  logic [31:0] exp_res = '0;
  string       exp_tag = "R11";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 1'b0; exp_done = 1'b0; exp_res = '0; exp_tag = "R11";
    end else begin
      exp_done = 1'b0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 1'b0; exp_done = 1'b1; exp_res = m_res; exp_tag = m_tag;
        end
      end else if (start) begin
        m_busy = 1'b1;
        m_left = func[2] ? 33 : 1;
        m_res  = ref_calc(func, a, b);
        m_tag  = tag_of(func, a, b);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R11 busy", {31'b0, busy}, {31'b0, m_busy});
      chk("R10 done timing", {31'b0, done}, {31'b0, exp_done});
      chk(exp_tag, result, exp_res);
    end
  end

  task automatic run(logic [2:0] f, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    start = 1'b1; func = f; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    @(negedge clk);
    // R11 reset state
    chk("R11 reset busy", {31'b0, busy}, 32'd0);
    chk("R11 reset done", {31'b0, done}, 32'd0);
    chk("R11 reset result", result, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    run(3'b000, 32'd7, 32'd6);                     // R1
    run(3'b000, 32'hFFFFFFFF, 32'hFFFFFFFF);        // R1
    run(3'b001, 32'h80000000, 32'h80000000);        // R2
    run(3'b001, 32'hFFFFFFFE, 32'd3);               // R2
    run(3'b010, 32'hFFFFFFFF, 32'hFFFFFFFF);        // R3
    run(3'b010, 32'h7FFFFFFF, 32'h80000000);        // R3
    run(3'b011, 32'hFFFFFFFF, 32'hFFFFFFFF);        // R4
    run(3'b100, 32'hFFFFFFF9, 32'd2);               // R5 -7/2 = -3
    run(3'b101, 32'hFFFFFFF9, 32'd2);               // R5
    run(3'b110, 32'hFFFFFFF9, 32'd2);               // R6 -7%2 = -1
    run(3'b110, 32'd7, 32'hFFFFFFFE);               // R6 7%-2 = 1
    run(3'b111, 32'd100, 32'd7);                    // R6
    run(3'b100, 32'h12345678, 32'd0);               // R7
    run(3'b101, 32'd0, 32'd0);                      // R7
    run(3'b110, 32'h80000001, 32'd0);               // R8
    run(3'b111, 32'hDEADBEEF, 32'd0);               // R8
    run(3'b100, 32'h80000000, 32'hFFFFFFFF);        // R9
    run(3'b110, 32'h80000000, 32'hFFFFFFFF);        // R9
    run(3'b101, 32'hFFFFFFFF, 32'd1);               // R5 boundary

    // R11: start held while busy with other operands is ignored
    @(negedge clk);
    start = 1'b1; func = 3'b100; a = 32'd1000; b = 32'd7;
    @(negedge clk);
    func = 3'b000; a = 32'd3; b = 32'd3;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);

    // R10/R11: start held high issues back-to-back multiplies
    @(negedge clk);
    start = 1'b1; func = 3'b011; a = 32'hA5A5A5A5; b = 32'h5A5A5A5A;
    repeat (6) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);

    for (int i = 0; i < 200; i++) begin
      logic [31:0] x, y;
      x = $urandom();
      y = $urandom();
      if (i % 9 == 0) y = 32'd0;
      if (i % 5 == 0) y = {28'b0, y[3:0]} | 32'd0;
      run(3'($urandom_range(0, 7)), x, y);
    end

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule